// File: doc/BRIEF.md
# Programmable BERT Pattern Generator/Checker

This block is a bit-error-rate test engine for a serial stream that moves one bit per enabled clock. The transmit half produces a test pattern chosen from three families: a 2^9-1 pseudorandom sequence, a quasi-random signal source (QRSS) built on a 2^20-1 sequence with zero suppression, and a user repetitive word of 1 to 32 bits. It can corrupt the outgoing stream one bit at a time or on every bit.

The receive half locks onto the incoming pattern by predicting each bit from the bits it has already seen. Once locked it counts the bits it evaluates and the bits that disagree with its prediction. It drops lock when errors bunch up, and then relocks from the incoming data. A latch strobe moves both counts into holding outputs and restarts the live counters. The bit enable input gates both halves, so the engine can be confined to selected time slots of a frame.

Top module: `bert_engine`

## Requirements
- R1: When `bit_en` is low, neither the generator nor the checker advances: `tx_bit` keeps its value, the pattern resumes where it stopped, `in_sync` holds, and no bit or error is counted.
- R2: With `mode` = 2'b00, the enabled transmit bits follow b[n] = b[n-9] XOR b[n-5] (x^9+x^5+1), with every bit before the first taken as one after reset.
- R3: With `mode` = 2'b01, a raw sequence r[n] = r[n-20] XOR r[n-17] (x^20+x^17+1, bits before reset taken as one) is sent. A bit that follows fourteen consecutive transmitted zeros is sent as one, so no run of zeros is longer than fourteen.
- R4: With `mode[1]` = 1, the transmitted bits are `user_pat[0]`, `user_pat[1]`, … `user_pat[user_len]`, then repeat. The pattern length is `user_len`+1, from 1 to 32 bits, and the first bit after reset is bit 0.
- R5: A one-cycle `inj_single` pulse, even on a cycle with `bit_en` low, inverts exactly one transmitted bit: the first enabled bit at or after the pulse.
- R6: While `inj_cont` is high, every enabled transmitted bit is inverted.
- R7: `in_sync` is low after reset. It rises after 32 consecutive enabled received bits that match the checker's prediction, and it can never rise before the 32nd enabled bit.
- R8: While `in_sync` is high, each enabled bit adds one to the bit count, and each mismatch adds one to the error count. A single corrupted bit counts as exactly one error, with no multiplication of errors.
- R9: Errors are counted in fixed 64-bit windows, the first starting with the first bit after lock. Five errors in a window keep lock. The sixth error in a window drops `in_sync` on that bit, and lock returns after 32 further matching bits.
- R10: A `latch` pulse copies both counts, including the current cycle's bit, into `bits_held` and `errs_held`, and restarts the live counts at zero. Without `latch` the held values do not change. Both held values are zero after reset.
- R11: Both counters saturate at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit enable; one bit is sent and one is checked per cycle while high |
| mode | input | 2 | Pattern select: 00 PRBS 2^9-1, 01 QRSS, 1x user word |
| user_pat | input | UPAT_W | User repetitive pattern, sent LSB first |
| user_len | input | LEN_W | User pattern length minus one |
| inj_single | input | 1 | Request inversion of one transmitted bit |
| inj_cont | input | 1 | Invert every transmitted bit while high |
| tx_bit | output | 1 | Generated bit, valid for the current enabled cycle |
| rx_bit | input | 1 | Received bit, sampled when bit_en is high |
| latch | input | 1 | Copy counts to held outputs and clear live counts |
| in_sync | output | 1 | Checker locked to the received pattern |
| bits_held | output | CNT_W | Latched count of bits evaluated in lock |
| errs_held | output | CNT_W | Latched count of errored bits |

## Verification
The bench loops the generator back to the checker through an optional bit flip. It places errors at known positions in the 64-bit window: five errors must leave lock intact, and a sixth must drop it on that exact bit. A checker that resynchronised on every error, or that used a sliding window, would disagree on the cycle where `in_sync` falls or on the relock count. A single-error pulse applied while the enable is low must land on the next enabled bit only. A pending flag that ignored the enable would lose the error, and one that never cleared would corrupt more bits. Error counts after isolated flips must equal the number of flips, which catches a checker that shifts received bits into its predictor while locked and triples every error. The latch-on-an-enabled-bit case and a 10-bit counter run past its limit check that no bit is lost at the latch boundary and that the counters do not wrap.

// File: rtl/bert_engine.sv
module bert_engine #(
  parameter int CNT_W    = 32,
  parameter int UPAT_W   = 32,
  parameter int ACQ_RUN  = 32,
  parameter int WIN_LEN  = 64,
  parameter int WIN_ERR  = 6,
  parameter int QZ_MAX   = 14,
  localparam int LEN_W   = $clog2(UPAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [1:0]        mode,
  input  logic [UPAT_W-1:0] user_pat,
  input  logic [LEN_W-1:0]  user_len,
  input  logic              inj_single,
  input  logic              inj_cont,
  output logic              tx_bit,
  input  logic              rx_bit,
  input  logic              latch,
  output logic              in_sync,
  output logic [CNT_W-1:0]  bits_held,
  output logic [CNT_W-1:0]  errs_held
);
  localparam int LFSR_W = 20;
  localparam int HIST_W = (UPAT_W > LFSR_W) ? UPAT_W : LFSR_W;
  localparam int QZ_W   = $clog2(QZ_MAX + 1);
  localparam int ACQ_W  = $clog2(ACQ_RUN + 1);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int WE_W   = $clog2(WIN_ERR + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  wire is_user = mode[1];
  wire is_qrss = (mode == 2'b01);

  // generator
  logic [LFSR_W-1:0] g;
  logic [QZ_W-1:0]   gz;
  logic [LEN_W-1:0]  gp;
  logic              pend;

  wire g_raw = is_qrss ? (g[19] ^ g[16]) : (g[8] ^ g[4]);
  wire g_pat = is_user ? user_pat[gp]
             : (is_qrss && gz == QZ_W'(QZ_MAX)) ? 1'b1 : g_raw;
  wire inj   = inj_cont | pend | inj_single;
  assign tx_bit = g_pat ^ inj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g    <= '1;
      gz   <= '0;
      gp   <= '0;
      pend <= 1'b0;
    end else begin
      pend <= (pend | inj_single) & ~bit_en;
      if (bit_en) begin
        g  <= {g[LFSR_W-2:0], g_raw};
        gz <= g_pat ? '0 : ((gz == QZ_W'(QZ_MAX)) ? gz : gz + 1'b1);
        gp <= (gp >= user_len) ? '0 : gp + 1'b1;
      end
    end
  end

  // checker
  logic [HIST_W-1:0] h;
  logic [QZ_W-1:0]   cz;
  logic              sync_q;
  logic [ACQ_W-1:0]  run;
  logic [WIN_W-1:0]  wpos;
  logic [WE_W-1:0]   wer;
  logic [CNT_W-1:0]  bc, ec;

  wire c_raw  = is_qrss ? (h[19] ^ h[16]) : (h[8] ^ h[4]);
  wire c_frc  = is_qrss && cz == QZ_W'(QZ_MAX);
  wire c_pred = is_user ? h[user_len] : (c_frc ? 1'b1 : c_raw);
  wire mism   = rx_bit ^ c_pred;
  wire c_fill = sync_q ? (is_user ? c_pred : c_raw)
              : (c_frc ? c_raw : rx_bit);
  wire c_seen = sync_q ? c_pred : rx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h      <= '0;
      cz     <= '0;
      sync_q <= 1'b0;
      run    <= '0;
      wpos   <= '0;
      wer    <= '0;
    end else if (bit_en) begin
      h  <= {h[HIST_W-2:0], c_fill};
      cz <= c_seen ? '0 : ((cz == QZ_W'(QZ_MAX)) ? cz : cz + 1'b1);
      if (!sync_q) begin
        if (mism) run <= '0;
        else if (run == ACQ_W'(ACQ_RUN - 1)) begin
          sync_q <= 1'b1;
          run    <= '0;
          wpos   <= '0;
          wer    <= '0;
        end else run <= run + 1'b1;
      end else if (mism && wer == WE_W'(WIN_ERR - 1)) begin
        sync_q <= 1'b0;
        run    <= '0;
        wpos   <= '0;
        wer    <= '0;
      end else if (wpos == WIN_W'(WIN_LEN - 1)) begin
        wpos <= '0;
        wer  <= '0;
      end else begin
        wpos <= wpos + 1'b1;
        wer  <= wer + WE_W'(mism);
      end
    end
  end

  assign in_sync = sync_q;

  // counters
  wire take = bit_en && sync_q;
  wire [CNT_W-1:0] bc_n = (take && bc != CMAX) ? bc + 1'b1 : bc;
  wire [CNT_W-1:0] ec_n = (take && mism && ec != CMAX) ? ec + 1'b1 : ec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc        <= '0;
      ec        <= '0;
      bits_held <= '0;
      errs_held <= '0;
    end else if (latch) begin
      bits_held <= bc_n;
      errs_held <= ec_n;
      bc        <= '0;
      ec        <= '0;
    end else begin
      bc <= bc_n;
      ec <= ec_n;
    end
  end

  AST_GEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(g) && $stable(gp)); // R1
  AST_SINGLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    pend && bit_en |=> !pend); // R5
  AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> $past(bit_en)); // R7
  AST_ERR_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ec <= bc); // R8
  AST_LOSS_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_q) |-> $past(bit_en && mism)); // R9
  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> bc == '0 && ec == '0); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(bits_held) && $stable(errs_held)); // R10
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    bc == CMAX && !latch |=> bc == CMAX); // R11
endmodule

// File: tb/tb_bert_engine.sv
module tb_bert_engine;
  localparam int CLK_P = 10;
  localparam int CW = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic bit_en = 0;
  logic [1:0] mode = 2'b00;
  logic [31:0] user_pat = '0;
  logic [4:0] user_len = '0;
  logic inj_single = 0, inj_cont = 0, latch = 0, flip = 0;
  logic tx_bit, rx_bit, in_sync;
  logic [CW-1:0] bits_held, errs_held;

  assign rx_bit = tx_bit ^ flip;

  bert_engine #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode(mode),
    .user_pat(user_pat), .user_len(user_len), .inj_single(inj_single),
    .inj_cont(inj_cont), .tx_bit(tx_bit), .rx_bit(rx_bit), .latch(latch),
    .in_sync(in_sync), .bits_held(bits_held), .errs_held(errs_held));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [19:0] mh;
  int mz, mp;
  int tx_mis, stall_mis, first_mis, en_idx, zrun, zmax, forced;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic m_raw();
    return (mode == 2'b01) ? (mh[19] ^ mh[16]) : (mh[8] ^ mh[4]);
  endfunction

  function automatic logic m_exp();
    if (mode[1]) return user_pat[mp];
    if (mode == 2'b01 && mz == 14) return 1'b1;
    return m_raw();
  endfunction

  task automatic m_adv();
    logic r, b;
    r = m_raw();
    b = m_exp();
    if (mode == 2'b01 && mz == 14 && !r) forced++;
    mh = {mh[18:0], r};
    mz = b ? 0 : mz + 1;
    mp = (mp >= int'(user_len)) ? 0 : mp + 1;
  endtask

  task automatic step(input logic en, input logic lat = 1'b0);
    logic e;
    bit_en = en;
    latch = lat;
    #(CLK_P/2 - 1);
    e = m_exp();
    if (en) begin
      if (tx_bit !== e) begin
        tx_mis++;
        if (first_mis < 0) first_mis = en_idx;
      end
      zrun = tx_bit ? 0 : zrun + 1;
      if (zrun > zmax) zmax = zrun;
      en_idx++;
      m_adv();
    end else if (tx_bit !== e && !inj_single && !inj_cont) stall_mis++;
    @(negedge clk);
    latch = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    mode = m;
    rst_n = 0; bit_en = 0; latch = 0; flip = 0; inj_single = 0; inj_cont = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mh = '1; mz = 0; mp = 0;
    tx_mis = 0; stall_mis = 0; first_mis = -1; en_idx = 0; zrun = 0; zmax = 0; forced = 0;
  endtask

  task automatic acquire();
    for (int i = 0; i < 80 && !in_sync; i++) step(1);
  endtask

  task automatic t_reset_state();
    do_reset(2'b00);
    chk(in_sync == 0, "R7", "in_sync after reset", in_sync, 0);
    chk(bits_held == 0 && errs_held == 0, "R10", "held counts after reset",
        bits_held + errs_held, 0);
  endtask

  task automatic t_prbs9();
    int early;
    do_reset(2'b00);
    early = -1;
    for (int i = 0; i < 300; i++) begin
      step((i % 3) != 2);
      if (en_idx == 31) early = in_sync;
    end
    chk(tx_mis == 0, "R2", "prbs9 bit mismatches", tx_mis, 0);
    chk(stall_mis == 0, "R1", "tx_bit moved while disabled", stall_mis, 0);
    chk(early == 0, "R7", "in_sync before 32 bits", early, 0);
    chk(in_sync == 1, "R7", "prbs9 lock", in_sync, 1);
  endtask

  task automatic t_qrss();
    do_reset(2'b01);
    for (int i = 0; i < 120000; i++) step(1);
    step(0, 1'b1);
    chk(tx_mis == 0, "R3", "qrss bit mismatches", tx_mis, 0);
    chk(zmax <= 14, "R3", "longest zero run", zmax, 14);
    chk(in_sync == 1 && errs_held == 0, "R3", "qrss lock errors", errs_held, 0);
    $display("info: qrss forced ones seen %0d", forced);
  endtask

  task automatic t_user();
    do_reset(2'b10);
    user_pat = 32'h0000_00B5; user_len = 5'd7;
    for (int i = 0; i < 40; i++) step(1);
    chk(tx_mis == 0, "R4", "8-bit user pattern", tx_mis, 0);
    do_reset(2'b11);
    user_pat = 32'h8000_0001; user_len = 5'd31;
    for (int i = 0; i < 100; i++) step(1);
    step(0, 1'b1);
    chk(tx_mis == 0, "R4", "32-bit user pattern", tx_mis, 0);
    chk(in_sync == 1 && errs_held == 0, "R4", "32-bit user lock", in_sync, 1);
    do_reset(2'b10);
    user_pat = 32'h0000_0001; user_len = 5'd0;
    for (int i = 0; i < 20; i++) step(1);
    chk(tx_mis == 0, "R4", "1-bit user pattern", tx_mis, 0);
  endtask

  task automatic t_gating();
    do_reset(2'b00);
    acquire();
    step(0, 1'b1);
    flip = 1;
    for (int i = 0; i < 20; i++) step(0);
    flip = 0;
    step(0, 1'b1);
    chk(bits_held == 0 && errs_held == 0, "R1", "counts while disabled",
        bits_held + errs_held, 0);
    chk(in_sync == 1, "R1", "lock kept while disabled", in_sync, 1);
    for (int i = 0; i < 10; i++) step(1);
    chk(tx_mis == 0 && stall_mis == 0, "R1", "pattern resumes", tx_mis + stall_mis, 0);
  endtask

  task automatic t_counts();
    do_reset(2'b00);
    acquire();
    step(0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      flip = (i == 5 || i == 17 || i == 30);
      step(1);
    end
    flip = 0;
    step(0, 1'b1);
    chk(bits_held == 40, "R8", "bit count", bits_held, 40);
    chk(errs_held == 3, "R8", "error count, one per flip", errs_held, 3);
    for (int i = 0; i < 25; i++) step(1, i == 24);
    chk(bits_held == 25 && errs_held == 0, "R10", "latch on enabled bit", bits_held, 25);
    for (int i = 0; i < 10; i++) step(1);
    chk(bits_held == 25, "R10", "held value without latch", bits_held, 25);
    step(0, 1'b1);
    chk(bits_held == 10, "R10", "count restarted after latch", bits_held, 10);
  endtask

  task automatic t_inject();
    do_reset(2'b00);
    acquire();
    step(0, 1'b1);
    tx_mis = 0; first_mis = -1;
    inj_single = 1;
    step(0);
    inj_single = 0;
    repeat (3) step(0);
    en_idx = 0;
    for (int i = 0; i < 30; i++) step(1);
    chk(tx_mis == 1 && first_mis == 0, "R5", "single inversion count", tx_mis, 1);
    step(0, 1'b1);
    chk(errs_held == 1, "R5", "single error counted", errs_held, 1);
    tx_mis = 0;
    inj_cont = 1;
    for (int i = 0; i < 4; i++) step(1);
    inj_cont = 0;
    for (int i = 0; i < 10; i++) step(1);
    chk(tx_mis == 4, "R6", "continuous inversions", tx_mis, 4);
    step(0, 1'b1);
    chk(errs_held == 4, "R6", "continuous errors counted", errs_held, 4);
  endtask

  task automatic t_loss();
    int k;
    do_reset(2'b00);
    acquire();
    k = 0;
    for (int i = 0; i < 64; i++) begin
      flip = (k >= 10 && k <= 14);
      step(1); k++;
    end
    flip = 0;
    chk(in_sync == 1, "R9", "five errors keep lock", in_sync, 1);
    for (int i = 0; i < 16; i++) begin
      flip = (i >= 10);
      step(1);
    end
    flip = 0;
    chk(in_sync == 0, "R9", "sixth error drops lock", in_sync, 1'b0);
    for (int i = 0; i < 31; i++) step(1);
    chk(in_sync == 0, "R9", "no relock before 32 bits", in_sync, 0);
    step(1);
    chk(in_sync == 1, "R9", "relock after 32 bits", in_sync, 1);
  endtask

  task automatic t_saturate();
    do_reset(2'b00);
    acquire();
    step(0, 1'b1);
    for (int i = 0; i < 1100; i++) step(1);
    step(0, 1'b1);
    chk(bits_held == 10'h3FF, "R11", "bit count saturates", bits_held, 1023);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_prbs9();
    t_user();
    t_gating();
    t_counts();
    t_inject();
    t_loss();
    t_saturate();
    t_qrss();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule